// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns the 16-bit logical addresses of a small processor into 15-bit physical addresses. It uses a page table held on chip. The top four address bits select one of sixteen table entries. The low twelve bits pass through as the offset within the page. A resident entry supplies a 3-bit frame number, and the frame number placed above the offset gives the physical address. Any page may sit in any of the eight frames. An access to a page that is not resident reports a page fault and produces no address.

Each entry also keeps bookkeeping that a replacement routine outside the block can use. A dirty flag records that the page has been written since it was loaded, so a clean page can be dropped without a write-back. A small saturating counter records how often the page was used. A host port loads entries, which installs a frame and makes the entry resident, and invalidates entries. A status port shows any single entry combinationally so that the host can inspect it.

A request is accepted in any cycle. Its result appears in the following cycle, with the fault flag and the address registered together.

Top module: `xlat_unit`

## Requirements
- R1: After reset, rsp_valid, rsp_fault and rsp_paddr are 0, and every entry reads back through the status port with valid, dirty, count and frame all 0.
- R2: rsp_valid is 1 in exactly the cycle that follows a cycle with req_valid at 1, and 0 otherwise.
- R3: A request to a resident page returns rsp_fault 0 and rsp_paddr equal to the entry's frame in bits 14:12 and req_addr bits 11:0 in bits 11:0. The page number is req_addr bits 15:12.
- R4: A request to a page whose valid bit is 0 returns rsp_fault 1 and rsp_paddr 0.
- R5: A host load (host_load at 1) sets the entry at host_page to valid 1 and frame host_frame, and clears its dirty bit and count. The change is visible on the status port in the next cycle.
- R6: A host invalidate (host_inval at 1) clears the valid bit of the entry at host_page and leaves its frame, dirty and count as they were. Later requests to that page fault.
- R7: A successful write request (req_write at 1) sets the entry's dirty bit. A successful read leaves the dirty bit unchanged.
- R8: Each successful request increments the entry's 4-bit count by one, and the count stays at 15 once it gets there.
- R9: A faulting request changes no field of any entry.
- R10: When a host load or invalidate targets the same page as a request in the same cycle, the request is answered from the table as it stood before the edge, and its dirty and count update is dropped. The host operation takes effect.
- R11: When host_load and host_inval are both 1 in one cycle, the load wins and the entry ends up valid.
- R12: While rsp_valid is 0, rsp_fault and rsp_paddr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | Request is a write access |
| req_addr | input | 16 | Logical address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_fault | output | 1 | Page fault for the request |
| rsp_paddr | output | 15 | Physical address, 0 on a fault |
| host_load | input | 1 | Install a frame into the entry at host_page |
| host_inval | input | 1 | Clear the valid bit of the entry at host_page |
| host_page | input | 4 | Entry chosen by the host |
| host_frame | input | 3 | Frame number for a load |
| stat_page | input | 4 | Entry shown on the status outputs |
| stat_valid | output | 1 | Valid bit of the chosen entry |
| stat_dirty | output | 1 | Dirty bit of the chosen entry |
| stat_count | output | 4 | Usage count of the chosen entry |
| stat_frame | output | 3 | Frame number of the chosen entry |

## Verification
The hardest case to reach is a host operation and a request that hit the same page in the same edge. The request must be answered from the old entry, and its dirty and count update must be lost. Directed steps line up a load with a write to the same page, and a load with an invalidate. Counter saturation needs more than fifteen hits on one page with no reload in between, so a directed burst of reads provides it. The random phase uses a fixed seed. It weights requests heavily and host operations lightly, so that entries live long enough to collect dirty bits and high counts. A reference table in the bench predicts every response and every status read.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    parameter int LOG_AW  = 16;
    parameter int PHYS_AW = 15;
    parameter int OFF_W   = 12;
    parameter int CNT_W   = 4;

    localparam int PAGE_W  = LOG_AW - OFF_W;
    localparam int FRAME_W = PHYS_AW - OFF_W;
    localparam int N_PAGES = 1 << PAGE_W;

    typedef struct packed {
        logic               valid;
        logic               dirty;
        logic [CNT_W-1:0]   count;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    typedef struct packed {
        logic               valid;
        logic               fault;
        logic [PHYS_AW-1:0] paddr;
    } rsp_t;
endpackage

// File: rtl/xlat_table.sv
module xlat_table
    import xlat_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_load,
    input  logic                          host_inval,
    input  logic [PAGE_W-1:0]             host_page,
    input  logic [FRAME_W-1:0]            host_frame,
    input  logic                          acc_en,
    input  logic                          acc_write,
    input  logic [PAGE_W-1:0]             acc_page,
    output pte_t [N_PAGES-1:0]            table_o
);
    for (genvar g = 0; g < N_PAGES; g++) begin : g_entry
        pte_t ent_d, ent_q;
        logic host_sel;
        logic acc_sel;

        always_comb begin
            host_sel = (host_page == PAGE_W'(g)) && (host_load || host_inval);
            acc_sel  = acc_en && (acc_page == PAGE_W'(g)) && !host_sel;
            ent_d    = ent_q;
            if (acc_sel) begin
                if (ent_q.count != {CNT_W{1'b1}}) begin
                    ent_d.count = ent_q.count + CNT_W'(1);
                end
                if (acc_write) begin
                    ent_d.dirty = 1'b1;
                end
            end
            if (host_sel && host_inval) begin
                ent_d.valid = 1'b0;
            end
            if (host_sel && host_load) begin
                ent_d.valid = 1'b1;
                ent_d.dirty = 1'b0;
                ent_d.count = '0;
                ent_d.frame = host_frame;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign table_o[g] = ent_q;
    end
endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
    import xlat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [LOG_AW-1:0]    req_addr,
    input  pte_t [N_PAGES-1:0]   table_i,
    output logic                 acc_en,
    output logic                 acc_write,
    output logic [PAGE_W-1:0]    acc_page,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic [PHYS_AW-1:0]   rsp_paddr
);
    rsp_t             rsp_d, rsp_q;
    pte_t             sel;
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  offset;

    always_comb begin
        page      = req_addr[LOG_AW-1:OFF_W];
        offset    = req_addr[OFF_W-1:0];
        sel       = table_i[page];
        acc_en    = req_valid && sel.valid;
        acc_write = req_write;
        acc_page  = page;
        rsp_d     = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            if (sel.valid) begin
                rsp_d.paddr = {sel.frame, offset};
            end else begin
                rsp_d.fault = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [LOG_AW-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic                 rsp_fault,
    output logic [PHYS_AW-1:0]   rsp_paddr,
    input  logic                 host_load,
    input  logic                 host_inval,
    input  logic [PAGE_W-1:0]    host_page,
    input  logic [FRAME_W-1:0]   host_frame,
    input  logic [PAGE_W-1:0]    stat_page,
    output logic                 stat_valid,
    output logic                 stat_dirty,
    output logic [CNT_W-1:0]     stat_count,
    output logic [FRAME_W-1:0]   stat_frame
);
    pte_t [N_PAGES-1:0] tbl;
    logic               acc_en;
    logic               acc_write;
    logic [PAGE_W-1:0]  acc_page;
    pte_t               stat_ent;

    xlat_table i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_load  (host_load),
        .host_inval (host_inval),
        .host_page  (host_page),
        .host_frame (host_frame),
        .acc_en     (acc_en),
        .acc_write  (acc_write),
        .acc_page   (acc_page),
        .table_o    (tbl)
    );

    xlat_lookup i_lookup (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .table_i    (tbl),
        .acc_en     (acc_en),
        .acc_write  (acc_write),
        .acc_page   (acc_page),
        .rsp_valid  (rsp_valid),
        .rsp_fault  (rsp_fault),
        .rsp_paddr  (rsp_paddr)
    );

    always_comb begin
        stat_ent   = tbl[stat_page];
        stat_valid = stat_ent.valid;
        stat_dirty = stat_ent.dirty;
        stat_count = stat_ent.count;
        stat_frame = stat_ent.frame;
    end
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk
    import xlat_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [LOG_AW-1:0]    req_addr,
    input logic                 rsp_valid,
    input logic                 rsp_fault,
    input logic [PHYS_AW-1:0]   rsp_paddr,
    input logic                 host_load,
    input logic                 host_inval,
    input logic [PAGE_W-1:0]    host_page,
    input logic [FRAME_W-1:0]   host_frame,
    input logic [PAGE_W-1:0]    stat_page,
    input logic                 stat_valid,
    input logic                 stat_dirty,
    input logic [CNT_W-1:0]     stat_count,
    input logic [FRAME_W-1:0]   stat_frame
);
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_paddr == '0)); // R12
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0)); // R4
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_fault || rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]))); // R3
    AST_LOAD_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
        host_load |=> (stat_page != $past(host_page) ||
                       (stat_valid && !stat_dirty && stat_count == '0 &&
                        stat_frame == $past(host_frame)))); // R5
    AST_INVAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_inval && !host_load) |=> (stat_page != $past(host_page) || !stat_valid)); // R6
endmodule

bind xlat_unit xlat_unit_chk i_xlat_unit_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_paddr  (rsp_paddr),
    .host_load  (host_load),
    .host_inval (host_inval),
    .host_page  (host_page),
    .host_frame (host_frame),
    .stat_page  (stat_page),
    .stat_valid (stat_valid),
    .stat_dirty (stat_dirty),
    .stat_count (stat_count),
    .stat_frame (stat_frame)
);

// File: tb/test_xlat_unit.sv
`timescale 1ns/1ps
module test_xlat_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [14:0] rsp_paddr;
    logic        host_load = 1'b0;
    logic        host_inval = 1'b0;
    logic [3:0]  host_page = '0;
    logic [2:0]  host_frame = '0;
    logic [3:0]  stat_page = '0;
    logic        stat_valid;
    logic        stat_dirty;
    logic [3:0]  stat_count;
    logic [2:0]  stat_frame;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    bit       m_valid [16];
    bit       m_dirty [16];
    int       m_count [16];
    int       m_frame [16];

    always #4 clk = ~clk;

    xlat_unit i_xlat_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .host_load(host_load), .host_inval(host_inval),
        .host_page(host_page), .host_frame(host_frame),
        .stat_page(stat_page), .stat_valid(stat_valid), .stat_dirty(stat_dirty),
        .stat_count(stat_count), .stat_frame(stat_frame)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_paddr(int page, int off);
        return (m_frame[page] << 12) | off;
    endfunction

    task automatic chk_stat(int page, string tag);
        stat_page = 4'(page);
        #1;
        check({tag, " valid"}, int'(stat_valid), int'(m_valid[page]));
        check({tag, " dirty"}, int'(stat_dirty), int'(m_dirty[page]));
        check({tag, " count"}, int'(stat_count), m_count[page]);
        check({tag, " frame"}, int'(stat_frame), m_frame[page]);
    endtask

    task automatic step(bit rv, bit rw, logic [15:0] a, bit hl, bit hi,
                        logic [3:0] hp, logic [2:0] hf);
        int  page;
        int  off;
        bit  e_fault;
        int  e_addr;
        bit  hsel;
        @(negedge clk);
        req_valid = rv; req_write = rw; req_addr = a;
        host_load = hl; host_inval = hi; host_page = hp; host_frame = hf;
        page = int'(a[15:12]);
        off  = int'(a[11:0]);
        @(posedge clk);
        e_fault = rv && !m_valid[page];
        e_addr  = (rv && m_valid[page]) ? exp_paddr(page, off) : 0;
        hsel    = (hl || hi) && (int'(hp) == page);
        if (rv && m_valid[page] && !hsel) begin
            if (m_count[page] < 15) m_count[page]++;
            if (rw) m_dirty[page] = 1'b1;
        end
        if (hi) m_valid[int'(hp)] = 1'b0;
        if (hl) begin
            m_valid[int'(hp)] = 1'b1;
            m_dirty[int'(hp)] = 1'b0;
            m_count[int'(hp)] = 0;
            m_frame[int'(hp)] = int'(hf);
        end
        #1;
        check("R2 rsp_valid", int'(rsp_valid), int'(rv));
        if (!rv) begin
            check("R12 idle fault", int'(rsp_fault), 0);
            check("R12 idle paddr", int'(rsp_paddr), 0);
        end else if (e_fault) begin
            check("R4 fault", int'(rsp_fault), 1);
            check("R4 paddr", int'(rsp_paddr), 0);
        end else begin
            check("R3 fault", int'(rsp_fault), 0);
            check("R3 paddr", int'(rsp_paddr), e_addr);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 0; m_dirty[i] = 0; m_count[i] = 0; m_frame[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 rsp_valid", int'(rsp_valid), 0);
        check("R1 rsp_fault", int'(rsp_fault), 0);
        check("R1 rsp_paddr", int'(rsp_paddr), 0);
        for (int i = 0; i < 16; i++) chk_stat(i, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R4: miss on empty table
        step(1, 0, 16'h3abc, 0, 0, 0, 0);
        chk_stat(3, "R9 after fault");
        // R5: load page 3 with frame 5
        step(0, 0, 0, 1, 0, 4'd3, 3'd5);
        chk_stat(3, "R5 load");
        // R3 hit read, R7 read keeps clean
        step(1, 0, 16'h3abc, 0, 0, 0, 0);
        chk_stat(3, "R7 read clean");
        // R7 write sets dirty
        step(1, 1, 16'h3001, 0, 0, 0, 0);
        chk_stat(3, "R7 write dirty");
        // R8 saturation
        for (int k = 0; k < 20; k++) step(1, 0, 16'h3fff, 0, 0, 0, 0);
        chk_stat(3, "R8 saturate");
        check("R8 count at 15", int'(stat_count), 15);
        // R6 invalidate keeps other fields, later access faults
        step(0, 0, 0, 0, 1, 4'd3, 3'd0);
        chk_stat(3, "R6 inval");
        check("R6 dirty kept", int'(stat_dirty), 1);
        step(1, 1, 16'h3123, 0, 0, 0, 0);
        chk_stat(3, "R9 fault no change");
        // R10: load and write to same page same cycle
        step(0, 0, 0, 1, 0, 4'd7, 3'd2);
        step(1, 1, 16'h7044, 1, 0, 4'd7, 3'd6);
        chk_stat(7, "R10 host wins");
        check("R10 dirty dropped", int'(stat_dirty), 0);
        // R10: invalidate with read same cycle, answered from old entry
        step(1, 0, 16'h7055, 0, 1, 4'd7, 3'd0);
        chk_stat(7, "R10 inval wins");
        // R11: load and invalidate together
        step(0, 0, 0, 1, 1, 4'd9, 3'd4);
        chk_stat(9, "R11 load wins");
        check("R11 valid", int'(stat_valid), 1);
        // different pages in one cycle: host op on one, access on another
        step(1, 1, 16'h9100, 1, 0, 4'd2, 3'd1);
        chk_stat(9, "R7 other page");
        chk_stat(2, "R5 other page");

        // constrained random phase
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            bit rv, rw, hl, hi;
            logic [15:0] a;
            rv = ($urandom % 4) != 0;
            rw = $urandom % 2;
            a  = 16'($urandom);
            hl = ($urandom % 6) == 0;
            hi = ($urandom % 12) == 0;
            step(rv, rw, a, hl, hi, 4'($urandom), 3'($urandom));
            chk_stat(int'($urandom % 16), "R8 random status");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule